// File: doc/BRIEF.md
# MAC Management Port and Duplex Cross-Check

This block is a small word-addressed register set that sits beside an Ethernet MAC. Through it, software bit-bangs the PHY management bus: one control word sets the clock level, the output-enable and the data driven onto the serial management line. A status word returns the line as seen at the pad, after a synchronizer. The MDIO slave logic inside the PHY is not part of this block.

The same register set holds a receive-control word whose full-duplex bit tells how the MAC is configured. A PHY-side input carries the duplex that the PHY reports in its diagnostic register. The block recomputes whether the two disagree at two moments: when software rewrites receive control, and when a management write changes the clock level. Software normally polls the PHY with that clock, so the check runs again with every polled bit. The result is stored in a mismatch flag, but only while the MAC-enable bit of the general-control word is set. Whenever the stored flag changes value, a one-cycle change pulse is raised.

Top module: `mac_mgmt_duplex`

## Requirements
- R1: After reset, every register reads zero, and the clock, output-enable, data, mismatch and change outputs are all low.
- R2: A write to the management word (index 2) sets the clock output to bit 2 and the output-enable to bit 1, and the word reads back as written.
- R3: The data output takes bit 0 of a management write only when bit 1 of that same write is set; otherwise it keeps its value.
- R4: The status word (index 3) returns the data input pin in bit 0 after SYNC_STAGES clock cycles, with all other bits zero. Writes to it have no effect.
- R5: The general-control word (index 0) and the receive-control word (index 1) read back the last value written.
- R6: A write to receive control, while enabled, sets the mismatch flag to the XOR of the new bit 7 and the PHY duplex input.
- R7: A management write that changes the clock level re-evaluates the flag against the stored receive-control bit 7. A management write that keeps the level does not.
- R8: While general-control bit 0 is clear, the mismatch flag holds its value whatever events occur.
- R9: The change output is high for exactly the one cycle after an update that changes the flag, and it stays low when an evaluation returns the same value.
- R10: A change on the PHY duplex input alone, with no evaluating write, does not alter the flag.
- R11: A read from an unmapped index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Bus access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| mdc_o | output | 1 | Management clock level |
| mdio_o | output | 1 | Management data driven to the pad |
| mdio_oe_o | output | 1 | Pad output enable |
| mdio_i | input | 1 | Management data seen at the pad |
| phy_fd_i | input | 1 | Full-duplex state reported by the PHY |
| dup_mismatch_o | output | 1 | Stored duplex mismatch flag |
| dup_change_o | output | 1 | One-cycle pulse when the flag changes |

## Verification
The cross-check is driven through three kinds of trigger: writes to receive control, management writes that flip the clock, and management writes that leave the clock level unchanged. The last kind tells a correct edge detector apart from one that fires on every management write. Each trigger is tried with the MAC both matching and not matching the PHY duplex, and with the enable bit both set and clear. This shows that the flag follows only gated events and that the change pulse fires only on a real change of value. The PHY input is also toggled with no write at all, to prove the flag does not track it continuously. On the pad side, the bench writes data both with and without the enable bit, which tells apart a correctly gated data latch from one that always loads.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int unsigned DATA_W = 32;

  // word indices
  localparam int unsigned IDX_GEN  = 0;
  localparam int unsigned IDX_RX   = 1;
  localparam int unsigned IDX_MGMT = 2;
  localparam int unsigned IDX_STAT = 3;

  // bit positions decoded by software and by the monitor
  localparam int unsigned B_DOUT   = 0;
  localparam int unsigned B_OE     = 1;
  localparam int unsigned B_MDC    = 2;
  localparam int unsigned B_MAC_EN = 0;
  localparam int unsigned B_MAC_FD = 7;
  localparam int unsigned B_STAT   = 0;

  typedef struct packed {
    logic mdc;
    logic oe;
    logic dout;
  } mgmt_fields_t;

  function automatic mgmt_fields_t decode_mgmt(input logic [DATA_W-1:0] w);
    mgmt_fields_t f;
    f.mdc  = w[B_MDC];
    f.oe   = w[B_OE];
    f.dout = w[B_DOUT];
    return f;
  endfunction

  function automatic logic duplex_differs(input logic mac_fd, input logic phy_fd);
    return mac_fd ^ phy_fd;
  endfunction

endpackage

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
  import mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              status_bit,
  output logic              gen_wr,
  output logic              rx_wr,
  output logic              mgmt_wr,
  output logic              mac_en,
  output logic              rx_fd,
  output mgmt_fields_t      mgmt_q
);

  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(IDX_GEN);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(IDX_RX);
  localparam logic [ADDR_W-1:0] A_MGMT = ADDR_W'(IDX_MGMT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IDX_STAT);

  logic [DATA_W-1:0] gen_q, rx_q, mgmt_word_q;
  logic wr_any, rd_any;

  assign wr_any  = reg_valid & reg_write;
  assign rd_any  = reg_valid & ~reg_write;
  assign gen_wr  = wr_any & (reg_addr == A_GEN);
  assign rx_wr   = wr_any & (reg_addr == A_RX);
  assign mgmt_wr = wr_any & (reg_addr == A_MGMT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q       <= '0;
      rx_q        <= '0;
      mgmt_word_q <= '0;
    end else begin
      if (gen_wr)  gen_q       <= reg_wdata;
      if (rx_wr)   rx_q        <= reg_wdata;
      if (mgmt_wr) mgmt_word_q <= reg_wdata;
    end
  end

  assign mac_en = gen_q[B_MAC_EN];
  assign rx_fd  = rx_q[B_MAC_FD];
  assign mgmt_q = decode_mgmt(mgmt_word_q);

  always_comb begin
    reg_rdata = '0;
    if (rd_any) begin
      case (reg_addr)
        A_GEN:   reg_rdata = gen_q;
        A_RX:    reg_rdata = rx_q;
        A_MGMT:  reg_rdata = mgmt_word_q;
        A_STAT:  reg_rdata[B_STAT] = status_bit;
        default: reg_rdata = '0;
      endcase
    end
  end

  // R4: only the line bit of the status word may be nonzero
  assert_status_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && reg_addr == A_STAT) |-> (reg_rdata[DATA_W-1:1] == '0));

  // R11: unmapped indices read zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && reg_addr > A_STAT) |-> (reg_rdata == '0));

endmodule

// File: rtl/mdio_pad_ctrl.sv
module mdio_pad_ctrl
  import mgmt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mgmt_wr,
  input  mgmt_fields_t wr_fields,
  input  mgmt_fields_t mgmt_q,
  input  logic         mdio_i,
  output logic         mdc_o,
  output logic         mdio_oe_o,
  output logic         mdio_o,
  output logic         mdc_toggle,
  output logic         mdio_sync
);

  logic dout_q;

  // a management write whose clock bit differs from the present level
  assign mdc_toggle = mgmt_wr & (wr_fields.mdc != mgmt_q.mdc);

  always_ff @(posedge clk) begin
    if (!rst_n)                      dout_q <= 1'b0;
    else if (mgmt_wr && wr_fields.oe) dout_q <= wr_fields.dout;
  end

  assign mdc_o     = mgmt_q.mdc;
  assign mdio_oe_o = mgmt_q.oe;
  assign mdio_o    = dout_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign mdio_sync = mdio_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], mdio_i} & {SYNC_STAGES{1'b1}};
      end
      assign mdio_sync = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  // R2: clock level follows the written bit
  assert_mdc_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_wr |=> (mdc_o == $past(wr_fields.mdc)));

  // R3: data without enable leaves the pad data unchanged
  assert_mdio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && !wr_fields.oe) |=> $stable(mdio_o));

  // R3: data with enable is taken
  assert_mdio_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && wr_fields.oe) |=> (mdio_o == $past(wr_fields.dout)));

endmodule

// File: rtl/duplex_monitor.sv
module duplex_monitor
  import mgmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_wr,
  input  logic rx_wdata_fd,
  input  logic rx_fd,
  input  logic mdc_toggle,
  input  logic mac_en,
  input  logic phy_fd,
  output logic eval_evt,
  output logic flag_q,
  output logic chg_q
);

  logic mac_fd_next;
  logic verdict;
  logic do_update;

  assign eval_evt    = rx_wr | mdc_toggle;
  assign mac_fd_next = rx_wr ? rx_wdata_fd : rx_fd;
  assign verdict     = duplex_differs(mac_fd_next, phy_fd);
  assign do_update   = eval_evt & mac_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= do_update & (verdict != flag_q);
      if (do_update) flag_q <= verdict;
    end
  end

  // R6: an enabled evaluation stores the comparison result
  assert_flag_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && mac_en) |=> (flag_q == $past(mac_fd_next ^ phy_fd)));

  // R8: without an enabled evaluation the flag holds
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(eval_evt && mac_en) |=> $stable(flag_q));

  // R9: a pulse is seen only together with a change of the flag
  assert_pulse_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (flag_q != $past(flag_q)));

  // R9: every change of the flag carries a pulse
  assert_change_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != $past(flag_q)) |-> chg_q);

endmodule

// File: rtl/mac_mgmt_duplex.sv
module mac_mgmt_duplex
  import mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i,
  input  logic              phy_fd_i,
  output logic              dup_mismatch_o,
  output logic              dup_change_o
);

  logic         gen_wr, rx_wr, mgmt_wr;
  logic         mac_en, rx_fd;
  logic         mdc_toggle, mdio_sync, eval_evt;
  mgmt_fields_t mgmt_q, wr_fields;

  assign wr_fields = decode_mgmt(reg_wdata);

  mgmt_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .status_bit (mdio_sync),
    .gen_wr     (gen_wr),
    .rx_wr      (rx_wr),
    .mgmt_wr    (mgmt_wr),
    .mac_en     (mac_en),
    .rx_fd      (rx_fd),
    .mgmt_q     (mgmt_q)
  );

  mdio_pad_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_pad (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_wr    (mgmt_wr),
    .wr_fields  (wr_fields),
    .mgmt_q     (mgmt_q),
    .mdio_i     (mdio_i),
    .mdc_o      (mdc_o),
    .mdio_oe_o  (mdio_oe_o),
    .mdio_o     (mdio_o),
    .mdc_toggle (mdc_toggle),
    .mdio_sync  (mdio_sync)
  );

  duplex_monitor u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_wr       (rx_wr),
    .rx_wdata_fd (reg_wdata[B_MAC_FD]),
    .rx_fd       (rx_fd),
    .mdc_toggle  (mdc_toggle),
    .mac_en      (mac_en),
    .phy_fd      (phy_fd_i),
    .eval_evt    (eval_evt),
    .flag_q      (dup_mismatch_o),
    .chg_q       (dup_change_o)
  );

  // R8: writing general control never itself evaluates the flag
  assert_gen_no_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wr |=> $stable(dup_mismatch_o));

  // R7: a management write that keeps the clock level leaves the flag alone
  assert_same_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && wr_fields.mdc == mdc_o) |=> $stable(dup_mismatch_o));

endmodule

// File: tb/mac_mgmt_duplex_tb.sv
module mac_mgmt_duplex_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int SYNC       = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_valid = 1'b0;
  logic              reg_write = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mdc_o, mdio_o, mdio_oe_o;
  logic              mdio_i = 1'b0;
  logic              phy_fd_i = 1'b0;
  logic              dup_mismatch_o, dup_change_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic exp_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_mgmt_duplex #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i),
    .phy_fd_i(phy_fd_i), .dup_mismatch_o(dup_mismatch_o), .dup_change_o(dup_change_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = ADDR_W'(idx); reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = ADDR_W'(idx);
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  // write that evaluates the flag; bench model of R6/R8/R9
  task automatic eval_wr(input string req, input int idx, input logic [31:0] d,
                         input logic mac_fd, input logic en);
    logic prev;
    prev = exp_flag;
    if (en) exp_flag = mac_fd ^ phy_fd_i;
    wr(idx, d);
    check({req, " flag"}, dup_mismatch_o, exp_flag);
    check({req, " pulse"}, dup_change_o, prev != exp_flag);
    @(negedge clk);
    check({req, " pulse one cycle"}, dup_change_o, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      check("R1 reg zero", v, 0);
    end
    check("R1 outputs", {mdc_o, mdio_oe_o, mdio_o, dup_mismatch_o, dup_change_o}, 0);
  endtask

  task automatic t_pad();
    logic [31:0] v;
    wr(2, 32'h7);
    check("R2 mdc", mdc_o, 1); check("R2 oe", mdio_oe_o, 1); check("R3 load", mdio_o, 1);
    wr(2, 32'h4);
    check("R3 hold without oe", mdio_o, 1); check("R2 oe off", mdio_oe_o, 0);
    wr(2, 32'h2);
    check("R3 load zero", mdio_o, 0); check("R2 mdc low", mdc_o, 0);
    wr(2, 32'h1);
    check("R3 hold zero", mdio_o, 0);
    rd(2, v);
    check("R2 readback", v, 32'h1);
  endtask

  task automatic t_status();
    logic [31:0] v;
    mdio_i = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    rd(3, v);
    check("R4 status high", v, 1);
    wr(3, 32'hFFFF_FFFE);
    mdio_i = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    rd(3, v);
    check("R4 status low and write ignored", v, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(1, 32'hA5A5_0000);
    rd(1, v); check("R5 rx readback", v, 32'hA5A5_0000);
    wr(0, 32'h1234_5670);
    rd(0, v); check("R5 gen readback", v, 32'h1234_5670);
    rd(9, v); check("R11 unmapped", v, 0);
  endtask

  task automatic t_disabled();
    phy_fd_i = 1'b1;
    eval_wr("R8 rx write disabled", 1, 32'h0, 1'b0, 1'b0);
    eval_wr("R8 mdc toggle disabled", 2, 32'h4, 1'b0, 1'b0);
  endtask

  task automatic t_rx_eval();
    wr(0, 32'h1);
    check("R8 enable write no eval", dup_mismatch_o, 0);
    eval_wr("R9 match no pulse", 1, 32'h80, 1'b1, 1'b1);
    eval_wr("R6 mismatch", 1, 32'h0, 1'b0, 1'b1);
    eval_wr("R6 mismatch repeat", 1, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_mdc_eval();
    phy_fd_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 phy alone", dup_mismatch_o, 1);
    // mdc is 1 now (from t_disabled); keep the level
    wr(2, 32'h4);
    check("R7 same level no eval", dup_mismatch_o, 1);
    eval_wr("R7 mdc fall evaluates", 2, 32'h0, 1'b0, 1'b1);
    phy_fd_i = 1'b1;
    eval_wr("R7 mdc rise evaluates", 2, 32'h4, 1'b0, 1'b1);
    wr(0, 32'h0);
    phy_fd_i = 1'b0;
    eval_wr("R8 disabled hold", 2, 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pad();
    t_status();
    t_readback();
    t_disabled();
    t_rx_eval();
    t_mdc_eval();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule